// File: doc/BRIEF.md
# Parallel-Bus ADC Digital Controller

This block is the digital half of a 12-bit converter with a parallel microprocessor bus. A sampled data word and a 3-bit channel number arrive on ports in place of the analog front end. A falling edge on the active-low start strobe captures them. The controller then counts rising edges of a separate master conversion clock. On the thirteenth edge it moves the captured word into the output register and drops its busy flag. The master clock may run continuously or in bursts.

A host reads the result and writes a 12-bit control register through active-low select, read and write strobes. In word mode the whole 12-bit value moves in one transfer. In byte mode, data bit 8 becomes a high-byte select. The low byte then carries result bits 7..0. The high byte carries the top four result bits together with the channel that produced the result. Byte-mode writes are staged: the low byte first, then the high byte.

A parameter selects a 10-bit variant, in which the two least significant result bits always read as zero. The two low control bits select a power mode. In either automatic mode the block falls asleep after each conversion. A rising edge on the start strobe wakes it again. All strobes and the master clock are synchronised to the system clock.

Top module: `adc_parallel_if`

## Requirements
- R1: After reset, busy is 0, db_oe is 0, db_out is 0, ctrl_out is 0, and a word-mode read returns 0.
- R2: A falling edge on convst_n while idle and awake captures sample_in and chan_in and raises busy within 3 system clocks.
- R3: busy stays high through the first 12 rising edges of clkin after the start. On the 13th edge the captured word enters the result register and busy falls. Reads made during the conversion return the previous result.
- R4: A falling edge on convst_n while busy is ignored: the conversion keeps its original sample and ends on its original edge count.
- R5: db_oe is 1 only while cs_n and rd_n are both low. At all other times db_oe is 0 and db_out is 0.
- R6: With word_mode=1, a read drives the 12-bit result on db_out[11:0].
- R7: With word_mode=0 and db_in[8]=0, a read drives result[7:0] on db_out[7:0], with db_out[11:8]=0.
- R8: With word_mode=0 and db_in[8]=1, a read drives result[11:8] on db_out[3:0] and the result's channel on db_out[6:4], with db_out[11:7]=0.
- R9: With word_mode=1, a falling wr_n while cs_n is low loads db_in[11:0] into ctrl_out.
- R10: With word_mode=0, a write with db_in[8]=0 stages db_in[7:0] and leaves ctrl_out unchanged. A following write with db_in[8]=1 sets ctrl_out to {db_in[3:0], staged byte}.
- R11: A byte-mode high-byte write with db_in[7:4] nonzero is ignored and ctrl_out is unchanged.
- R12: With RES_BITS=10, result bits [1:0] always read as 0 and bits [11:2] carry sample_in[11:2].
- R13: When ctrl_out[1:0] is nonzero, the block sleeps after a conversion completes. While asleep, a falling convst_n starts nothing. A rising convst_n wakes the block, and the next falling edge starts a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clkin | input | 1 | Master conversion clock, asynchronous, continuous or burst |
| convst_n | input | 1 | Conversion start strobe, falling edge starts, rising edge wakes |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| word_mode | input | 1 | 1 = 12-bit word transfers, 0 = byte transfers with db_in[8] as high-byte select |
| db_in | input | 12 | Bus data from host; bit 8 is the high-byte select in byte mode |
| sample_in | input | 12 | Stand-in for the analog sample |
| chan_in | input | 3 | Channel number of the sample |
| busy | output | 1 | High while a conversion runs |
| db_out | output | 12 | Bus data to host, 0 when not driven |
| db_oe | output | 1 | Bus output enable (high = driven, low = high impedance) |
| ctrl_out | output | 12 | Current control register; bits [1:0] set the power mode |

## Verification
Each strobe passes two synchroniser flops and one edge or output register, so busy rises, db_oe and db_out settle, and ctrl_out updates on the third system clock after the input changes. busy falls on the third clock after the 13th clkin rise. The bench drives inputs on falling clock edges and holds each stimulus for at least five clocks before sampling outputs on a falling edge. The master clock is toggled by the bench only after a start has had time to register. This lets the bench know exactly which clkin edge is the 12th and which is the 13th.

// File: rtl/adc_pif_pkg.sv
package adc_pif_pkg;

  localparam int DATA_W   = 12;
  localparam int CHAN_W   = 3;
  localparam int LOW_W    = 8;
  localparam int NIB_W    = DATA_W - LOW_W;
  localparam int HBEN_BIT = LOW_W;
  localparam int CHAN_LSB = NIB_W;
  localparam int PWR_W    = 2;

  typedef enum logic [PWR_W-1:0] {
    PWR_ALWAYS_ON = 2'b00,
    PWR_AUTO_OFF  = 2'b01,
    PWR_AUTO_IDLE = 2'b10,
    PWR_AUTO_RSVD = 2'b11
  } pwr_mode_e;

  // Clear the bits below the converter's resolution.
  function automatic logic [DATA_W-1:0] trim_result(input logic [DATA_W-1:0] raw,
                                                    input int res_bits);
    logic [DATA_W-1:0] v;
    v = raw;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < DATA_W - res_bits) v[i] = 1'b0;
    end
    return v;
  endfunction

  // Bus image of the result for the selected transfer width and byte.
  function automatic logic [DATA_W-1:0] pack_read(input logic [DATA_W-1:0] res,
                                                  input logic [CHAN_W-1:0] chan,
                                                  input logic              word_sel,
                                                  input logic              high_sel);
    logic [DATA_W-1:0] v;
    v = '0;
    if (word_sel) begin
      v = res;
    end else if (high_sel) begin
      v[NIB_W-1:0]                 = res[DATA_W-1:LOW_W];
      v[CHAN_LSB+CHAN_W-1:CHAN_LSB] = chan;
    end else begin
      v[LOW_W-1:0] = res[LOW_W-1:0];
    end
    return v;
  endfunction

  // Any automatic mode puts the block to sleep after a conversion.
  function automatic logic pwr_sleeps(input logic [PWR_W-1:0] mode);
    return pwr_mode_e'(mode) != PWR_ALWAYS_ON;
  endfunction

endpackage

// File: rtl/adc_pif_sync.sv
module adc_pif_sync #(
  parameter int              WIDTH   = 5,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL[b]}};
      else        pipe <= {pipe[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = pipe[STAGES-1];
  end

endmodule

// File: rtl/adc_pif_edge.sv
module adc_pif_edge #(
  parameter bit DETECT_RISE = 1'b1,
  parameter bit RST_VAL     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  if (DETECT_RISE) begin : g_rise
    assign pulse = lvl & ~prev;
  end else begin : g_fall
    assign pulse = ~lvl & prev;
  end

endmodule

// File: rtl/adc_pif_conv.sv
module adc_pif_conv
  import adc_pif_pkg::*;
#(
  parameter int CONV_EDGES = 13,
  parameter int RES_BITS   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_fall,
  input  logic              start_rise,
  input  logic              clkin_rise,
  input  logic              sleep_en,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [CHAN_W-1:0] chan_in,
  output logic              busy,
  output logic              asleep,
  output logic              conv_start,
  output logic              conv_done,
  output logic [DATA_W-1:0] result,
  output logic [CHAN_W-1:0] result_chan
);

  localparam int CNT_W = $clog2(CONV_EDGES + 1);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(CONV_EDGES - 1);

  logic [CNT_W-1:0]  edge_cnt;
  logic [DATA_W-1:0] hold_word;
  logic [CHAN_W-1:0] hold_chan;

  assign conv_start = start_fall & ~busy & ~asleep;
  assign conv_done  = busy & clkin_rise & (edge_cnt == LAST_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      edge_cnt  <= '0;
      hold_word <= '0;
      hold_chan <= '0;
    end else if (conv_start) begin
      busy      <= 1'b1;
      edge_cnt  <= '0;
      hold_word <= trim_result(sample_in, RES_BITS);
      hold_chan <= chan_in;
    end else if (conv_done) begin
      busy     <= 1'b0;
      edge_cnt <= '0;
    end else if (busy && clkin_rise) begin
      edge_cnt <= edge_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      result_chan <= '0;
    end else if (conv_done) begin
      result      <= hold_word;
      result_chan <= hold_chan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          asleep <= 1'b0;
    else if (conv_done)  asleep <= sleep_en;
    else if (start_rise) asleep <= 1'b0;
  end

endmodule

// File: rtl/adc_pif_bus.sv
module adc_pif_bus
  import adc_pif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl_n,
  input  logic              rd_lvl_n,
  input  logic              wr_fall,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] db_in,
  input  logic [DATA_W-1:0] result,
  input  logic [CHAN_W-1:0] result_chan,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              ctrl_wr
);

  logic             read_en;
  logic             wr_evt;
  logic             high_sel;
  logic             upper_clear;
  logic             stage_wr;
  logic [LOW_W-1:0] stage_byte;

  assign read_en     = ~cs_lvl_n & ~rd_lvl_n;
  assign wr_evt      = wr_fall & ~cs_lvl_n;
  assign high_sel    = db_in[HBEN_BIT];
  assign upper_clear = (db_in[LOW_W-1:NIB_W] == '0);
  assign stage_wr    = wr_evt & ~word_mode & ~high_sel;
  assign ctrl_wr     = wr_evt & (word_mode | (high_sel & upper_clear));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_oe  <= 1'b0;
      db_out <= '0;
    end else begin
      db_oe  <= read_en;
      db_out <= read_en ? pack_read(result, result_chan, word_mode, high_sel) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_byte <= '0;
    else if (stage_wr) stage_byte <= db_in[LOW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= word_mode ? db_in : {db_in[NIB_W-1:0], stage_byte};
    end
  end

endmodule

// File: rtl/adc_parallel_if.sv
module adc_parallel_if
  import adc_pif_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int CONV_EDGES  = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkin,
  input  logic              convst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] db_in,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [CHAN_W-1:0] chan_in,
  output logic              busy,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe,
  output logic [DATA_W-1:0] ctrl_out
);

  localparam int N_SYNC = 5;
  localparam int I_CLKIN = 0;
  localparam int I_CONV  = 1;
  localparam int I_CS    = 2;
  localparam int I_RD    = 3;
  localparam int I_WR    = 4;
  localparam logic [N_SYNC-1:0] SYNC_RST = 5'b11110;

  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] lvl;
  logic              clkin_rise;
  logic              conv_fall;
  logic              conv_rise;
  logic              wr_fall;
  logic              asleep;
  logic              conv_start;
  logic              conv_done;
  logic              ctrl_wr;
  logic [DATA_W-1:0] result;
  logic [CHAN_W-1:0] result_chan;

  assign raw_in = {wr_n, rd_n, cs_n, convst_n, clkin};

  adc_pif_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(lvl)
  );

  adc_pif_edge #(.DETECT_RISE(1'b1), .RST_VAL(1'b0)) u_clkin_rise (
    .clk(clk), .rst_n(rst_n), .lvl(lvl[I_CLKIN]), .pulse(clkin_rise)
  );
  adc_pif_edge #(.DETECT_RISE(1'b0), .RST_VAL(1'b1)) u_conv_fall (
    .clk(clk), .rst_n(rst_n), .lvl(lvl[I_CONV]), .pulse(conv_fall)
  );
  adc_pif_edge #(.DETECT_RISE(1'b1), .RST_VAL(1'b1)) u_conv_rise (
    .clk(clk), .rst_n(rst_n), .lvl(lvl[I_CONV]), .pulse(conv_rise)
  );
  adc_pif_edge #(.DETECT_RISE(1'b0), .RST_VAL(1'b1)) u_wr_fall (
    .clk(clk), .rst_n(rst_n), .lvl(lvl[I_WR]), .pulse(wr_fall)
  );

  adc_pif_conv #(.CONV_EDGES(CONV_EDGES), .RES_BITS(RES_BITS)) u_conv (
    .clk(clk), .rst_n(rst_n),
    .start_fall(conv_fall), .start_rise(conv_rise), .clkin_rise(clkin_rise),
    .sleep_en(pwr_sleeps(ctrl_out[PWR_W-1:0])),
    .sample_in(sample_in), .chan_in(chan_in),
    .busy(busy), .asleep(asleep), .conv_start(conv_start), .conv_done(conv_done),
    .result(result), .result_chan(result_chan)
  );

  adc_pif_bus u_bus (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl_n(lvl[I_CS]), .rd_lvl_n(lvl[I_RD]), .wr_fall(wr_fall),
    .word_mode(word_mode), .db_in(db_in),
    .result(result), .result_chan(result_chan),
    .db_out(db_out), .db_oe(db_oe), .ctrl_q(ctrl_out), .ctrl_wr(ctrl_wr)
  );

endmodule

// File: rtl/adc_parallel_if_chk.sv
module adc_parallel_if_chk
  import adc_pif_pkg::*;
#(
  parameter int CONV_EDGES = 13,
  parameter int RES_BITS   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              asleep,
  input logic              conv_start,
  input logic              conv_done,
  input logic              clkin_rise,
  input logic              ctrl_wr,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] db_out,
  input logic              db_oe,
  input logic [DATA_W-1:0] ctrl_out
);

  localparam int CW = $clog2(CONV_EDGES + 1);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << (DATA_W - RES_BITS)) - 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  seen <= '0;
    else if (conv_start)         seen <= '0;
    else if (busy && clkin_rise) seen <= seen + 1'b1;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !busy);

  p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (seen == CW'(CONV_EDGES - 1)));

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(result));

  p_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !db_oe |-> (db_out == '0));

  p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_out));

  p_low_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (result & LOW_MASK) == '0);

  p_sleep_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !conv_start);

endmodule

bind adc_parallel_if adc_parallel_if_chk #(.CONV_EDGES(CONV_EDGES), .RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .asleep(asleep),
  .conv_start(conv_start), .conv_done(conv_done), .clkin_rise(clkin_rise),
  .ctrl_wr(ctrl_wr), .result(result), .db_out(db_out), .db_oe(db_oe),
  .ctrl_out(ctrl_out)
);

// File: tb/adc_parallel_if_test.sv
module adc_parallel_if_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clkin = 1'b0;
  logic        convst_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        word_mode = 1'b1;
  logic [11:0] db_in = '0;
  logic [11:0] sample_in = '0;
  logic [2:0]  chan_in = '0;

  logic        busy, db_oe, busy10, db_oe10;
  logic [11:0] db_out, ctrl_out, db_out10, ctrl_out10;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_parallel_if uut (
    .clk(clk), .rst_n(rst_n), .clkin(clkin), .convst_n(convst_n), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .word_mode(word_mode), .db_in(db_in),
    .sample_in(sample_in), .chan_in(chan_in), .busy(busy), .db_out(db_out),
    .db_oe(db_oe), .ctrl_out(ctrl_out)
  );

  adc_parallel_if #(.RES_BITS(10)) uut10 (
    .clk(clk), .rst_n(rst_n), .clkin(clkin), .convst_n(convst_n), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .word_mode(word_mode), .db_in(db_in),
    .sample_in(sample_in), .chan_in(chan_in), .busy(busy10), .db_out(db_out10),
    .db_oe(db_oe10), .ctrl_out(ctrl_out10)
  );

  function automatic logic [11:0] expect_bus(input logic [11:0] res, input logic [2:0] ch,
                                             input logic wm, input logic hb);
    if (wm) return res;
    if (hb) return {5'b00000, ch, res[11:8]};
    return {4'h0, res[7:0]};
  endfunction

  function automatic logic [11:0] ten_bit(input logic [11:0] s);
    return {s[11:2], 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      clkin = 1'b1; wait_clk(4);
      clkin = 1'b0; wait_clk(4);
    end
  endtask

  task automatic start_pulse();
    convst_n = 1'b0; wait_clk(6);
    convst_n = 1'b1; wait_clk(6);
  endtask

  task automatic do_read(input logic wm, input logic hb,
                         output logic [11:0] d, output logic oe, output logic [11:0] d10);
    word_mode = wm; db_in = '0; db_in[8] = hb;
    cs_n = 1'b0; rd_n = 1'b0; wait_clk(5);
    d = db_out; oe = db_oe; d10 = db_out10;
    cs_n = 1'b1; rd_n = 1'b1; wait_clk(5);
  endtask

  task automatic do_write(input logic wm, input logic [11:0] v);
    word_mode = wm; db_in = v;
    cs_n = 1'b0; wr_n = 1'b0; wait_clk(5);
    wr_n = 1'b1; cs_n = 1'b1; wait_clk(5);
  endtask

  task automatic convert(input logic [11:0] s, input logic [2:0] c);
    sample_in = s; chan_in = c;
    start_pulse();
    clkin_pulses(13);
    wait_clk(2);
  endtask

  task automatic check_result(input string req, input logic [11:0] s, input logic [2:0] c);
    logic [11:0] d, d10; logic oe;
    do_read(1'b1, 1'b0, d, oe, d10);
    check({req, " R6 word"}, d, s);
    check({req, " R12 word10"}, d10, ten_bit(s));
    do_read(1'b0, 1'b0, d, oe, d10);
    check({req, " R7 low"}, d, expect_bus(s, c, 1'b0, 1'b0));
    check({req, " R12 low10"}, d10, expect_bus(ten_bit(s), c, 1'b0, 1'b0));
    do_read(1'b0, 1'b1, d, oe, d10);
    check({req, " R8 high"}, d, expect_bus(s, c, 1'b0, 1'b1));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] d, d10, s, ctrl_exp;
    logic [2:0]  c;
    logic        oe;
    void'($urandom(32'd5318));

    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 busy", busy, 1'b0);
    check("R1 db_oe", db_oe, 1'b0);
    check("R1 db_out", db_out, 12'h000);
    check("R1 ctrl", ctrl_out, 12'h000);
    do_read(1'b1, 1'b0, d, oe, d10);
    check("R1 read", d, 12'h000);
    check("R5 oe during read", oe, 1'b1);

    // R2 / R3 directed conversion
    sample_in = 12'hA5F; chan_in = 3'd5;
    convst_n = 1'b0; wait_clk(5);
    check("R2 busy rise", busy, 1'b1);
    convst_n = 1'b1; wait_clk(5);
    clkin_pulses(12);
    wait_clk(3);
    check("R3 busy after 12 edges", busy, 1'b1);
    do_read(1'b1, 1'b0, d, oe, d10);
    check("R3 old result during busy", d, 12'h000);
    clkin_pulses(1);
    check("R3 busy after 13 edges", busy, 1'b0);
    check_result("R3", 12'hA5F, 3'd5);

    // R4 restart ignored while busy
    sample_in = 12'h123; chan_in = 3'd2;
    start_pulse();
    clkin_pulses(5);
    sample_in = 12'hFED; chan_in = 3'd7;
    start_pulse();
    clkin_pulses(7);
    wait_clk(2);
    check("R4 still busy", busy, 1'b1);
    clkin_pulses(1);
    check("R4 busy end", busy, 1'b0);
    check_result("R4", 12'h123, 3'd2);

    // R5 strobe qualification
    word_mode = 1'b1; cs_n = 1'b0; rd_n = 1'b1; wait_clk(5);
    check("R5 cs only oe", db_oe, 1'b0);
    check("R5 cs only data", db_out, 12'h000);
    cs_n = 1'b1; rd_n = 1'b0; wait_clk(5);
    check("R5 rd only oe", db_oe, 1'b0);
    rd_n = 1'b1; wait_clk(5);

    // R9 word write, R10 byte staging, R11 illegal high byte
    do_write(1'b1, 12'h3C0);
    check("R9 word write", ctrl_out, 12'h3C0);
    do_write(1'b0, 12'h0B4);
    check("R10 low byte staged only", ctrl_out, 12'h3C0);
    do_write(1'b0, 12'h107);
    check("R10 high byte commit", ctrl_out, 12'h7B4);
    do_write(1'b0, 12'h117);
    check("R11 nonzero upper ignored", ctrl_out, 12'h7B4);
    check("R10 variant ctrl", ctrl_out10, 12'h7B4);

    // random conversions and writes
    for (int it = 0; it < 14; it++) begin
      s = 12'($urandom); c = 3'($urandom);
      convert(s, c);
      check("R3 random done", busy, 1'b0);
      check_result("R6 random", s, c);
      ctrl_exp = 12'($urandom) & 12'hFFC;
      if (it % 2 == 0) begin
        do_write(1'b1, ctrl_exp);
      end else begin
        do_write(1'b0, {4'h0, ctrl_exp[7:0]});
        do_write(1'b0, {4'h1, 4'h0, ctrl_exp[11:8]});
      end
      check("R10 random ctrl", ctrl_out, ctrl_exp);
    end

    // R13 auto power-down
    do_write(1'b1, 12'h001);
    check("R13 mode set", ctrl_out, 12'h001);
    convert(12'h456, 3'd3);
    check_result("R13 first", 12'h456, 3'd3);
    sample_in = 12'h999; chan_in = 3'd1;
    convst_n = 1'b0; wait_clk(5);
    check("R13 asleep no start", busy, 1'b0);
    convst_n = 1'b1; wait_clk(6);
    check("R13 still idle after wake", busy, 1'b0);
    convst_n = 1'b0; wait_clk(5);
    check("R13 start after wake", busy, 1'b1);
    convst_n = 1'b1; wait_clk(5);
    clkin_pulses(13);
    wait_clk(2);
    check("R13 conversion done", busy, 1'b0);
    check_result("R13 second", 12'h999, 3'd1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule